// File: doc/BRIEF.md
# Serial Output Shifter with Selectable Shift Clock

This block turns a byte held in an 8-bit register into a serial bit stream on one output line. Software-side logic loads the register through a write strobe. The load itself starts the transfer, so no separate start command exists. A 3-bit mode field selects the event that advances the shifter:

- the timer underflow strobe;
- the system clock phase pulse;
- the rising edge of an external clock, after synchronisation to the system clock;
- a free-running recirculating mode, paced by the timer strobe, in which the byte rotates out and back in endlessly.

Bits leave most-significant first. A shift-clock output pulses in the cycle in which each new bit appears on the data line. In every mode except free-running, a completion flag rises once the whole byte has gone out, and the shifter then stops. Reading or writing the register clears the flag. With the mode field's top bit low, the shifter stays idle and the data line keeps its last bit.

Top module: `ser_shift_unit`

## Requirements
- R1: While reset is high, and in the first cycle after it, sdo, sclk_out and done_flag are 0 and rd_data is 0.
- R2: A write (wr_en high at a clock edge) loads wr_data into the register, so rd_data shows it from the next cycle. The write also clears done_flag, zeroes the bit count and arms the shifter.
- R3: Each shift moves the register's most significant bit to sdo and moves the register left by one. In modes 101, 110 and 111 a 0 enters the least significant bit.
- R4: In mode 101, each clock edge with tmr_strobe high shifts once while the shifter is armed.
- R5: In mode 110, each clock edge with sys_phase high shifts once while the shifter is armed.
- R6: In mode 111, a rising edge of ext_clk is synchronised through two flops. It causes one shift at the third clock edge that samples ext_clk high.
- R7: In modes 101, 110 and 111, the eighth shift after a write sets done_flag and disarms the shifter. Further shift events then change nothing until the next write.
- R8: In mode 100, each tmr_strobe rotates the register, feeding the outgoing most significant bit back into the least significant position. done_flag is never set and shifting never stops.
- R9: A read (rd_en high at a clock edge) clears done_flag. If a completing shift happens at the same edge, the set wins.
- R10: With mode[2] low (modes 000 to 011), no shift occurs. sdo and rd_data hold their values.
- R11: sclk_out is high for exactly the cycle after each edge at which a shift happened, and low otherwise.
- R12: When a write and a shift event coincide, the write wins. No bit is shifted and sclk_out stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Byte to load |
| rd_en | input | 1 | Register read strobe (clears done flag) |
| rd_data | output | 8 | Current register contents |
| mode | input | 3 | Shift clock source / mode select |
| tmr_strobe | input | 1 | Timer underflow strobe |
| sys_phase | input | 1 | System clock phase pulse |
| ext_clk | input | 1 | Asynchronous external shift clock |
| sdo | output | 1 | Serial data out |
| sclk_out | output | 1 | Shift clock pulse out |
| done_flag | output | 1 | Byte-complete interrupt flag |

## Verification
The bench builds the block with its default parameters: an 8-bit register and two synchroniser stages. Those values give a byte-complete flag after eight shifts and a three-edge latency on the external clock, and both are small enough to walk through bit by bit. With an 8-bit width, a free run of nineteen strobes ends on a rotation by three positions, which the bench checks against a computed byte. The same width makes a mid-transfer snapshot after three strobes distinguishable from the loaded value.

// File: rtl/ssu_pkg.sv
package ssu_pkg;

    typedef enum logic [1:0] {
        SRC_NONE  = 2'd0,
        SRC_TIMER = 2'd1,
        SRC_PHASE = 2'd2,
        SRC_EXT   = 2'd3
    } src_e;

    typedef struct packed {
        src_e src;
        logic recirc;
    } mode_cfg_t;

    localparam logic [2:0] MODE_FREE = 3'b100;

    function automatic mode_cfg_t decode_mode(input logic [2:0] m);
        mode_cfg_t c;
        c.recirc = (m == MODE_FREE);
        if (!m[2]) begin
            c.src = SRC_NONE;
        end else begin
            case (m[1:0])
                2'b00, 2'b01: c.src = SRC_TIMER;
                2'b10:        c.src = SRC_PHASE;
                default:      c.src = SRC_EXT;
            endcase
        end
        return c;
    endfunction

endpackage

// File: rtl/ssu_ext_sync.sv
module ssu_ext_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic ext_in,
    output logic rise_o
);
    logic [STAGES-1:0] chain;
    logic              hist;

    for (genvar i = 0; i < STAGES; i++) begin : g_stage
        if (i == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) chain[0] <= 1'b0;
                else     chain[0] <= ext_in;
            end
        end else begin : g_rest
            always_ff @(posedge clk) begin
                if (rst) chain[i] <= 1'b0;
                else     chain[i] <= chain[i-1];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) hist <= 1'b0;
        else     hist <= chain[STAGES-1];
    end

    assign rise_o = chain[STAGES-1] & ~hist;
endmodule

// File: rtl/ssu_clk_select.sv
module ssu_clk_select
    import ssu_pkg::*;
(
    input  mode_cfg_t cfg,
    input  logic      tmr_strobe,
    input  logic      sys_phase,
    input  logic      ext_rise,
    output logic      shift_ev
);
    always_comb begin
        case (cfg.src)
            SRC_TIMER: shift_ev = tmr_strobe;
            SRC_PHASE: shift_ev = sys_phase;
            SRC_EXT:   shift_ev = ext_rise;
            default:   shift_ev = 1'b0;
        endcase
    end
endmodule

// File: rtl/ssu_shifter.sv
module ssu_shifter #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [WIDTH-1:0] wr_data,
    input  logic             rd_en,
    input  logic             recirc,
    input  logic             shift_ev,
    output logic [WIDTH-1:0] shreg,
    output logic             sdo,
    output logic             sclk,
    output logic             done
);
    localparam int CNT_W = (WIDTH > 1) ? $clog2(WIDTH) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(WIDTH - 1);

    logic [CNT_W-1:0] cnt;
    logic             active;
    logic             fill_bit;
    logic             do_shift;

    assign fill_bit = recirc ? shreg[WIDTH-1] : 1'b0;
    assign do_shift = shift_ev & active & ~wr_en;

    always_ff @(posedge clk) begin
        if (rst) begin
            shreg  <= '0;
            cnt    <= '0;
            active <= 1'b0;
            sdo    <= 1'b0;
            sclk   <= 1'b0;
            done   <= 1'b0;
        end else begin
            sclk <= do_shift;
            if (wr_en) begin
                shreg  <= wr_data;
                cnt    <= '0;
                done   <= 1'b0;
                active <= 1'b1;
            end else begin
                if (rd_en) done <= 1'b0;
                if (do_shift) begin
                    sdo   <= shreg[WIDTH-1];
                    shreg <= {shreg[WIDTH-2:0], fill_bit};
                    cnt   <= (cnt == LAST) ? '0 : cnt + 1'b1;
                    if (!recirc && cnt == LAST) begin
                        done   <= 1'b1;
                        active <= 1'b0;
                    end
                end
            end
        end
    end
endmodule

// File: rtl/ser_shift_unit.sv
module ser_shift_unit
    import ssu_pkg::*;
#(
    parameter int WIDTH       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [WIDTH-1:0] wr_data,
    input  logic             rd_en,
    output logic [WIDTH-1:0] rd_data,
    input  logic [2:0]       mode,
    input  logic             tmr_strobe,
    input  logic             sys_phase,
    input  logic             ext_clk,
    output logic             sdo,
    output logic             sclk_out,
    output logic             done_flag
);
    mode_cfg_t cfg;
    logic      ext_rise;
    logic      shift_ev;

    assign cfg = decode_mode(mode);

    ssu_ext_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst    (rst),
        .ext_in (ext_clk),
        .rise_o (ext_rise)
    );

    ssu_clk_select u_sel (
        .cfg        (cfg),
        .tmr_strobe (tmr_strobe),
        .sys_phase  (sys_phase),
        .ext_rise   (ext_rise),
        .shift_ev   (shift_ev)
    );

    ssu_shifter #(.WIDTH(WIDTH)) u_shift (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_en),
        .wr_data  (wr_data),
        .rd_en    (rd_en),
        .recirc   (cfg.recirc),
        .shift_ev (shift_ev),
        .shreg    (rd_data),
        .sdo      (sdo),
        .sclk     (sclk_out),
        .done     (done_flag)
    );
endmodule

// File: rtl/ssu_checker.sv
module ssu_checker #(
    parameter int WIDTH = 8
) (
    input logic             clk,
    input logic             rst,
    input logic             wr_en,
    input logic [WIDTH-1:0] wr_data,
    input logic             rd_en,
    input logic [WIDTH-1:0] rd_data,
    input logic [2:0]       mode,
    input logic             sdo,
    input logic             sclk_out,
    input logic             done_flag
);
    // R2: a write lands in the register
    a_r2_write_loads: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> (rd_data == $past(wr_data)));

    // R2 / R12: a write leaves the done flag low
    a_r2_write_clears_done: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> !done_flag);

    // R12: no shift pulse after a write edge
    a_r12_write_wins: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> !sclk_out);

    // R3: the bit now on sdo was the top bit before the shift
    a_r3_msb_first: assert property (@(posedge clk) disable iff (rst)
        $rose(sclk_out) |-> (sdo == $past(rd_data[WIDTH-1])));

    // R10: idle modes hold sdo and do not pulse
    a_r10_idle_hold: assert property (@(posedge clk) disable iff (rst)
        !mode[2] |=> ($stable(sdo) && !sclk_out));

    // R8: free-running mode never raises the done flag
    a_r8_free_no_done: assert property (@(posedge clk) disable iff (rst)
        (mode == 3'b100 && !done_flag) |=> !done_flag);

    // R9: a read in an idle mode clears the flag
    a_r9_read_clears: assert property (@(posedge clk) disable iff (rst)
        (rd_en && !mode[2] && !wr_en) |=> !done_flag);
endmodule

bind ser_shift_unit ssu_checker #(.WIDTH(WIDTH)) u_ssu_chk (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (wr_en),
    .wr_data   (wr_data),
    .rd_en     (rd_en),
    .rd_data   (rd_data),
    .mode      (mode),
    .sdo       (sdo),
    .sclk_out  (sclk_out),
    .done_flag (done_flag)
);

// File: tb/ser_shift_unit_bench.sv
module ser_shift_unit_bench;
    localparam int CLK_PERIOD = 10;
    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         wr_en = 1'b0;
    logic [W-1:0] wr_data = '0;
    logic         rd_en = 1'b0;
    logic [W-1:0] rd_data;
    logic [2:0]   mode = 3'b000;
    logic         tmr_strobe = 1'b0;
    logic         sys_phase = 1'b0;
    logic         ext_clk = 1'b0;
    logic         sdo, sclk_out, done_flag;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ser_shift_unit u_ser_shift_unit (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
        .rd_en(rd_en), .rd_data(rd_data), .mode(mode),
        .tmr_strobe(tmr_strobe), .sys_phase(sys_phase), .ext_clk(ext_clk),
        .sdo(sdo), .sclk_out(sclk_out), .done_flag(done_flag)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // behavioural reference model
    int m_reg = 0, m_cnt = 0;
    bit m_done = 0, m_act = 0, m_sdo = 0, m_sclk = 0;
    bit x1 = 0, x2 = 0, x3 = 0;

    always @(posedge clk) begin
        bit ev;
        bit outbit;
        if (rst) begin
            m_reg = 0; m_cnt = 0; m_done = 0; m_act = 0; m_sdo = 0; m_sclk = 0;
            x1 = 0; x2 = 0; x3 = 0;
        end else begin
            ev = 0;
            if (mode[2]) begin
                if (mode[1:0] == 2'b10)      ev = sys_phase;
                else if (mode[1:0] == 2'b11) ev = x2 && !x3;
                else                         ev = tmr_strobe;
            end
            x3 = x2; x2 = x1; x1 = ext_clk;
            m_sclk = 0;
            if (wr_en) begin
                m_reg = wr_data; m_cnt = 0; m_done = 0; m_act = 1;
            end else begin
                if (rd_en) m_done = 0;
                if (ev && m_act) begin
                    outbit = m_reg[W-1];
                    m_sdo = outbit;
                    m_reg = ((m_reg << 1) & 8'hFF) | ((mode == 3'b100) ? int'(outbit) : 0);
                    m_sclk = 1;
                    if (mode != 3'b100 && m_cnt == W-1) begin m_done = 1; m_act = 0; end
                    m_cnt = (m_cnt + 1) % W;
                end
            end
        end
    end

    always @(negedge clk) begin
        if (!rst && !finished) begin
            check(sdo == m_sdo, "R3 sdo", sdo, m_sdo);
            check(sclk_out == m_sclk, "R11 sclk_out", sclk_out, m_sclk);
            check(done_flag == m_done, "R7 done_flag", done_flag, m_done);
            check(rd_data == m_reg[W-1:0], "R2 rd_data", rd_data, m_reg);
        end
    end

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_write(input logic [W-1:0] d, input bit strobe);
        wr_data = d; wr_en = 1; tmr_strobe = strobe;
        cyc(1);
        wr_en = 0; tmr_strobe = 0;
    endtask

    task automatic strobes(input int n);
        for (int i = 0; i < n; i++) begin
            tmr_strobe = 1; cyc(1);
            tmr_strobe = 0; cyc(1);
        end
    endtask

    initial begin
        cyc(3);
        check(sdo == 0 && sclk_out == 0 && done_flag == 0 && rd_data == 0,
              "R1 reset", {sdo, sclk_out, done_flag}, 0);
        rst = 0;
        cyc(1);
        check(rd_data == 0 && done_flag == 0, "R1 after reset", rd_data, 0);

        // R4: timer-paced shift-out
        mode = 3'b101;
        do_write(8'hA5, 0);
        check(rd_data == 8'hA5, "R2 load", rd_data, 8'hA5);
        strobes(3);
        check(rd_data == 8'h28, "R4 three strobes", rd_data, 8'h28);
        strobes(5);
        check(done_flag == 1, "R7 done after byte", done_flag, 1);
        check(rd_data == 8'h00, "R3 zero fill", rd_data, 0);
        strobes(2);
        check(rd_data == 8'h00 && done_flag == 1, "R7 stopped", rd_data, 0);
        rd_en = 1; cyc(1); rd_en = 0;
        check(done_flag == 0, "R9 read clears", done_flag, 0);

        // R5: system phase pacing, back to back
        mode = 3'b110;
        do_write(8'h3C, 0);
        sys_phase = 1; cyc(12); sys_phase = 0;
        check(done_flag == 1, "R5 phase byte done", done_flag, 1);

        // R6: synchronised external clock
        mode = 3'b111;
        do_write(8'h81, 0);
        check(done_flag == 0, "R2 write clears done", done_flag, 0);
        for (int i = 0; i < 8; i++) begin
            ext_clk = 1; cyc(3); ext_clk = 0; cyc(3);
        end
        cyc(4);
        check(done_flag == 1, "R6 ext byte done", done_flag, 1);

        // R8: free-running rotate
        mode = 3'b100;
        do_write(8'hB4, 0);
        strobes(19);
        check(done_flag == 0, "R8 no done", done_flag, 0);
        check(rd_data == 8'hA5, "R8 rotated by 3", rd_data, 8'hA5);

        // R10: idle mode
        mode = 3'b010;
        do_write(8'h55, 0);
        begin
            logic hold;
            hold = sdo;
            strobes(4);
            sys_phase = 1; cyc(3); sys_phase = 0;
            check(sdo == hold, "R10 sdo held", sdo, hold);
            check(rd_data == 8'h55, "R10 register held", rd_data, 8'h55);
        end

        // R12: write coincides with a shift event
        mode = 3'b101;
        do_write(8'hF0, 0);
        strobes(2);
        do_write(8'h0F, 1);
        check(rd_data == 8'h0F && sclk_out == 0, "R12 write wins", rd_data, 8'h0F);
        strobes(8);
        check(done_flag == 1, "R12 fresh count", done_flag, 1);

        cyc(2);
        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++; errors++;
            $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule